// File: doc/BRIEF.md
# Microcoded Add-Shift Multiplier Controller

This block sequences an unsigned add-and-shift multiplier entirely from a small constant control store. A control address register selects one 12-bit control word per cycle. Each word carries two candidate successor addresses, a two-bit condition selector and four datapath strobes. A four-way multiplexer picks the condition to test: constant zero, the start request, the low multiplier bit or the counter-zero flag. A two-way multiplexer then uses that condition to choose which successor address is loaded. No next-state logic is hand-written; changing the control store changes the algorithm.

The datapath registers sit inside the block so that results can be observed. These are the multiplicand B, the accumulator A, the carry flag C, the multiplier/low-product register Q and the step counter P. Operands are loaded while the controller waits. A start request then runs one add-or-skip and one shift step per multiplier bit. The block returns to the waiting word with the 2n-bit product in A||Q.

Top module: `mseq_mult_top`

## Requirements
- R1: After reset the control address is 000, `avail_o` is 1, all four strobes are 0 and C is 0.
- R2: The control word has NEXT1 in bits 11:9, NEXT0 in 8:6, SEL in 5:4 and strobes in 3:0. Bit 0 is init, bit 1 is load, bit 2 is clear-carry and bit 3 is shift. The strobe outputs follow the word at the current address in the same cycle. In the waiting word (address 000) no strobe is active.
- R3: At address 000 with SEL=01, `go`=0 keeps the controller at 000. `go`=1 moves it to 001 at the next edge. Word 001 drives init and clear-carry (strobe pattern 0101) and jumps to 010. These clear A and C and load P with n-1.
- R4: Word 010 drives no strobe and tests Q0 (SEL=10). Q0=1 goes to 011, and Q0=0 goes to 100. Word 011 drives load, which sets A to A+B and C to the carry, and jumps to 100.
- R5: Word 100 drives clear-carry and shift (pattern 1100). On that edge C||A||Q shifts right by one with 0 entering and P decrements. The word tests Z (SEL=11), where Z means P equals 0 before the decrement. Z=1 goes to 000 and Z=0 goes to 010.
- R6: A completed run leaves B × Q(initial) in A||Q as a 2n-bit unsigned product, and C is 0.
- R7: From the edge that samples `go`=1, `avail_o` stays 0 for exactly 1 + 2n + k cycles, where k is the number of ones in the multiplier. It returns to 1 on the next edge. Load is seen k times, shift n times and init once.
- R8: Only the strobe patterns 0000, 0101, 0010 and 1100 ever appear. Addresses 101 to 111 hold words with no strobes that return to 000, and these addresses are never entered.
- R9: `go` is tested only at address 000. Pulsing it during a run changes neither the product nor the run length.
- R10: `load_b` and `load_q` capture `mcand_in` and `mplier_in` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, tested at the waiting word |
| load_b | input | 1 | Capture multiplicand |
| load_q | input | 1 | Capture multiplier |
| mcand_in | input | WIDTH | Multiplicand operand |
| mplier_in | input | WIDTH | Multiplier operand |
| init_o | output | 1 | Strobe bit 0: clear A, preset P |
| load_o | output | 1 | Strobe bit 1: add B into A |
| clrc_o | output | 1 | Strobe bit 2: clear carry |
| shift_o | output | 1 | Strobe bit 3: shift C\|\|A\|\|Q, decrement P |
| avail_o | output | 1 | Controller at waiting word 000 |
| product_o | output | 2*WIDTH | A\|\|Q |

## Verification
The assertions assume that operands are loaded only while `avail_o` is 1. They also assume that `load_q` is never raised in the same cycle as a shift, because the counter and branch checks rely on Q changing only through the shift. The stimulus loads operands during waiting cycles only. It drops `go` one cycle after each start, so a run never restarts unexpectedly. The one exception is the deliberate mid-run pulse, which is timed to fall while the controller is away from address 000.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] uaddr_t;

  typedef struct packed {
    logic [ADDR_W-1:0] nxt1;
    logic [ADDR_W-1:0] nxt0;
    logic [1:0]        sel;
    logic [3:0]        strb;
  } uword_t;

  localparam uaddr_t A_IDLE = 3'd0;
  localparam uaddr_t A_INIT = 3'd1;
  localparam uaddr_t A_MUL0 = 3'd2;
  localparam uaddr_t A_ADD  = 3'd3;
  localparam uaddr_t A_MUL1 = 3'd4;

  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_GO   = 2'd1;
  localparam logic [1:0] SEL_Q0   = 2'd2;
  localparam logic [1:0] SEL_Z    = 2'd3;

  localparam int SB_INIT  = 0;
  localparam int SB_LOAD  = 1;
  localparam int SB_CLRC  = 2;
  localparam int SB_SHIFT = 3;

  // Control store contents, one word per address.
  function automatic uword_t ucode_word(input uaddr_t a);
    uword_t w;
    case (a)
      A_IDLE:  w = '{nxt1: A_INIT, nxt0: A_IDLE, sel: SEL_GO,   strb: 4'b0000};
      A_INIT:  w = '{nxt1: A_IDLE, nxt0: A_MUL0, sel: SEL_NONE, strb: 4'b0101};
      A_MUL0:  w = '{nxt1: A_ADD,  nxt0: A_MUL1, sel: SEL_Q0,   strb: 4'b0000};
      A_ADD:   w = '{nxt1: A_IDLE, nxt0: A_MUL1, sel: SEL_NONE, strb: 4'b0010};
      A_MUL1:  w = '{nxt1: A_IDLE, nxt0: A_MUL0, sel: SEL_Z,    strb: 4'b1100};
      default: w = '{nxt1: A_IDLE, nxt0: A_IDLE, sel: SEL_NONE, strb: 4'b0000};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
(
  input  uaddr_t addr_i,
  output uword_t word_o
);
  uword_t rom_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom_arr[g] = ucode_word(uaddr_t'(g));
  end

  assign word_o = rom_arr[addr_i];
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
  import mseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  logic   q0,
  input  logic   zero,
  input  uword_t word_i,
  output uaddr_t car_o,
  output logic   cond_o
);
  uaddr_t car_q;
  uaddr_t car_nxt;
  logic   cond;

  always_comb begin
    case (word_i.sel)
      SEL_GO:  cond = go;
      SEL_Q0:  cond = q0;
      SEL_Z:   cond = zero;
      default: cond = 1'b0;
    endcase
  end

  assign car_nxt = cond ? word_i.nxt1 : word_i.nxt0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= A_IDLE;
    else        car_q <= car_nxt;
  end

  assign car_o  = car_q;
  assign cond_o = cond;

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (car_q == A_IDLE && !go) |=> car_q == A_IDLE);
  assert_go_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (car_q == A_IDLE && go) |=> car_q == A_INIT);
  assert_init_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    car_q == A_INIT |=> car_q == A_MUL0);
  assert_q0_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    car_q == A_MUL0 |=> car_q == ($past(q0) ? A_ADD : A_MUL1));
  assert_add_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    car_q == A_ADD |=> car_q == A_MUL1);
  assert_z_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    car_q == A_MUL1 |=> car_q == ($past(zero) ? A_IDLE : A_MUL0));
  assert_legal_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    car_q <= A_MUL1);
endmodule

// File: rtl/mseq_datapath.sv
module mseq_datapath #(
  parameter int WIDTH = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_b,
  input  logic               load_q,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  input  logic               s_init,
  input  logic               s_load,
  input  logic               s_clrc,
  input  logic               s_shift,
  output logic               q0_o,
  output logic               zero_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0] P_START = PW'(WIDTH - 1);

  logic [WIDTH-1:0] b_q, a_q, q_q;
  logic             c_q;
  logic [PW-1:0]    p_q;
  logic [WIDTH:0]   sum_w;
  logic [2*WIDTH-1:0] shifted_w;

  // Accumulate with carry out in the top bit.
  function automatic logic [WIDTH:0] add_carry(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // Right shift of C||A||Q, returning the new A||Q.
  function automatic logic [2*WIDTH-1:0] shift_caq(input logic c,
                                                   input logic [WIDTH-1:0] a,
                                                   input logic [WIDTH-1:0] q);
    logic [2*WIDTH:0] whole;
    whole = {c, a, q} >> 1;
    return whole[2*WIDTH-1:0];
  endfunction

  assign sum_w     = add_carry(a_q, b_q);
  assign shifted_w = shift_caq(c_q, a_q, q_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_q <= '0;
    else if (load_b) b_q <= mcand_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      q_q <= '0;
    end else if (s_shift) begin
      a_q <= shifted_w[2*WIDTH-1:WIDTH];
      q_q <= shifted_w[WIDTH-1:0];
    end else begin
      if (s_init)      a_q <= '0;
      else if (s_load) a_q <= sum_w[WIDTH-1:0];
      if (load_q)      q_q <= mplier_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      c_q <= 1'b0;
    else if (s_load) c_q <= sum_w[WIDTH];
    else if (s_clrc) c_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       p_q <= '0;
    else if (s_init)  p_q <= P_START;
    else if (s_shift) p_q <= p_q - 1'b1;
  end

  assign q0_o      = q_q[0];
  assign zero_o    = (p_q == '0);
  assign product_o = {a_q, q_q};

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_load && (s_init || s_shift || s_clrc)) && !(s_init && s_shift));
  assert_count_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_shift |=> p_q == $past(p_q) - 1'b1);
  assert_init_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_init |=> (a_q == '0 && !c_q && p_q == P_START));
  assert_carry_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_shift |=> !c_q);
  assert_shift_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_shift |=> q_q[WIDTH-1] == $past(a_q[0]));
endmodule

// File: rtl/mseq_mult_top.sv
module mseq_mult_top
  import mseq_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               load_b,
  input  logic               load_q,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic               init_o,
  output logic               load_o,
  output logic               clrc_o,
  output logic               shift_o,
  output logic               avail_o,
  output logic [2*WIDTH-1:0] product_o
);
  uaddr_t car;
  uword_t word;
  logic   cond;
  logic   q0, zero;

  mseq_rom rom_i (
    .addr_i (car),
    .word_o (word)
  );

  mseq_sequencer seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .q0     (q0),
    .zero   (zero),
    .word_i (word),
    .car_o  (car),
    .cond_o (cond)
  );

  mseq_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_b    (load_b),
    .load_q    (load_q),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .s_init    (init_o),
    .s_load    (load_o),
    .s_clrc    (clrc_o),
    .s_shift   (shift_o),
    .q0_o      (q0),
    .zero_o    (zero),
    .product_o (product_o)
  );

  assign init_o  = word.strb[SB_INIT];
  assign load_o  = word.strb[SB_LOAD];
  assign clrc_o  = word.strb[SB_CLRC];
  assign shift_o = word.strb[SB_SHIFT];
  assign avail_o = (car == A_IDLE);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> !(init_o || load_o || clrc_o || shift_o));
  assert_uncond_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word.sel == SEL_NONE) |-> !cond);
endmodule

// File: tb/mseq_mult_top_tb_top.sv
`timescale 1ns/1ps
module mseq_mult_top_tb_top;
  localparam int W = 5;
  localparam int NV = 9;
  localparam logic [2*W-1:0] VECS [NV] = '{
    {5'd23, 5'd19}, {5'd0, 5'd0}, {5'd31, 5'd31}, {5'd1, 5'd31}, {5'd31, 5'd1},
    {5'd17, 5'd0},  {5'd0, 5'd31}, {5'd21, 5'd10}, {5'd16, 5'd16}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, load_b = 1'b0, load_q = 1'b0;
  logic [W-1:0] mcand_in = '0, mplier_in = '0;
  logic init_o, load_o, clrc_o, shift_o, avail_o;
  logic [2*W-1:0] product_o;
  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  mseq_mult_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .load_b(load_b), .load_q(load_q),
    .mcand_in(mcand_in), .mplier_in(mplier_in),
    .init_o(init_o), .load_o(load_o), .clrc_o(clrc_o), .shift_o(shift_o),
    .avail_o(avail_o), .product_o(product_o)
  );

  function automatic logic [3:0] strobes();
    return {shift_o, clrc_o, load_o, init_o};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    mcand_in = a; mplier_in = b; load_b = 1'b1; load_q = 1'b1;
    @(negedge clk);
    load_b = 1'b0; load_q = 1'b0;
  endtask

  // Start a run; optionally pulse go mid-run. Samples at negedges.
  task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b, input bit pulse);
    int low_cnt = 0, n_init = 0, n_load = 0, n_shift = 0, ones = 0;
    bit legal = 1'b1, first_ok = 1'b0;
    logic [3:0] s;
    for (int i = 0; i < W; i++) ones += b[i];
    load_ops(a, b);
    check(product_o[W-1:0] == b, "R10", product_o[W-1:0], b);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!avail_o && low_cnt < 200) begin
      s = strobes();
      if (low_cnt == 0) first_ok = (s == 4'b0101);
      if (!(s == 4'b0000 || s == 4'b0101 || s == 4'b0010 || s == 4'b1100)) legal = 1'b0;
      n_init += s[0]; n_load += s[1]; n_shift += s[3];
      low_cnt++;
      if (pulse) go = (low_cnt == 3 || low_cnt == 4);
      @(negedge clk);
    end
    go = 1'b0;
    check(first_ok, "R3 init word pattern 0101", 0, 5);
    check(n_init == 1, "R3 init count", n_init, 1);
    check(n_load == ones, "R4 load count", n_load, ones);
    check(n_shift == W, "R5 shift count", n_shift, W);
    check(legal, "R8 strobe patterns", 0, 1);
    check(low_cnt == 1 + 2*W + ones, pulse ? "R9 run length" : "R7 run length",
          low_cnt, 1 + 2*W + ones);
    check(product_o == longint'(a) * longint'(b), pulse ? "R9 product" : "R6 product",
          product_o, longint'(a) * longint'(b));
    check(avail_o && strobes() == 4'b0000, "R2 quiet after run", strobes(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(avail_o == 1'b1, "R1 avail in reset", avail_o, 1);
    check(strobes() == 4'b0000, "R1 strobes in reset", strobes(), 0);
    check(product_o == '0, "R1 product in reset", product_o, 0);
    rst_n = 1'b1;
    // R3: hold in waiting word with go low
    begin
      bit held = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!avail_o || strobes() != 4'b0000) held = 1'b0;
      end
      check(held, "R3 idle hold", held, 1);
    end
    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_one(VECS[i][2*W-1:W], VECS[i][W-1:0], 1'b0);
    end
    // R9: go pulsed mid-run
    run_one(5'd23, 5'd19, 1'b1);
    run_one(5'd29, 5'd27, 1'b1);
    // R1: reset mid-run returns to waiting word
    load_ops(5'd9, 5'd7);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(avail_o && strobes() == 4'b0000, "R1 reset mid-run", avail_o, 1);
    rst_n = 1'b1;
    run_one(5'd9, 5'd7, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule